// File: doc/BRIEF.md
# Card Command Response Capture Queue

This block sits behind the command line of a memory card host. After the host issues a command, the block watches the serial response line. It locks onto the first low bit, which is the start bit, and counts in the frame length that the command's response type calls for. It packs the frame into 16-bit halfwords, and software pulls them out one at a time through a single pop port. A 48-bit frame yields three halfwords and a 136-bit frame yields eight. A one-cycle done pulse marks the end of the frame. For the checked short type, an error pulse reports a CRC-7 mismatch.

Software rebuilds the 32-bit payload of a short frame from its three halfwords. It shifts the first left by 24, shifts the second left by 8, and ORs in the upper byte of the third. A long frame's eight halfwords form four 32-bit words, taken in pairs with the most significant part first. Issuing a command throws away whatever the previous response left unread.

Top module: `rsp_capture`

## Requirements
- R1: `cmd_rsp_type` is sampled while `cmd_issue` is high. The codes are 0 = no response, 1 = 48-bit frame with CRC check, 2 = 136-bit frame, 3 = 48-bit frame without CRC check. For a code other than 0, capture starts on the first qualified low bit after the issue. Line bits seen while no capture is armed are ignored.
- R2: A 48-bit frame is stored as three halfwords. They pop out most significant first, and the frame's start bit lands in bit 15 of the first pop.
- R3: For a 136-bit frame, the first 8 received bits are discarded. The remaining 128 bits pop out as eight halfwords, most significant first.
- R4: `rsp_done` is high for exactly one cycle. It comes in the cycle after the edge that accepts the frame's final bit, or, for code 0, in the cycle after the issue edge. At that point `rsp_busy` is low and `fifo_count` equals the number of halfwords stored (3 or 8) when no pop has occurred.
- R5: For code 1 only, the block computes a CRC-7 (polynomial x^7+x^3+1, zero initial value) over frame bits 0 to 39, counted from the start bit. It compares the result with frame bits 40 to 46. A mismatch raises `rsp_crc_err` in the same cycle as `rsp_done`. Codes 2 and 3 never raise it.
- R6: `pop_data` shows the oldest unread halfword. A pop while `fifo_count` is 0 returns zero and leaves the count at zero.
- R7: A new `cmd_issue` empties the queue and abandons any capture in progress. `fifo_count` reads 0 in the next cycle.
- R8: A bit is sampled only in a cycle where `line_valid` is high. Cycles with `line_valid` low neither start nor advance a frame, whatever value `line_bit` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_issue | input | 1 | One-cycle pulse when a command is sent |
| cmd_rsp_type | input | 2 | Response type code for the issued command |
| line_valid | input | 1 | Qualifies `line_bit` for this cycle |
| line_bit | input | 1 | Serial response line sample |
| pop | input | 1 | Remove the oldest halfword |
| pop_data | output | 16 | Oldest halfword, zero when empty |
| fifo_count | output | 4 | Halfwords currently stored |
| rsp_busy | output | 1 | Capture armed or in progress |
| rsp_done | output | 1 | Response completed pulse |
| rsp_crc_err | output | 1 | CRC mismatch pulse, checked type only |

## Verification
A bit counter that slips by one position shifts every halfword, so the very first pop after the frame already differs from the expected value. An off-by-one in the frame length moves or drops the done pulse, and the bench samples that pulse exactly one cycle after the last bit. A stale CRC register, or a check that ignores the type, shows up at the next done pulse as a spurious or missing error. Pointer or flush faults show up as nonzero empty reads or as wrong counts right after a new issue.

// File: rtl/rspcap_pkg.sv
package rspcap_pkg;
   typedef enum logic [1:0] {
      RSP_NONE      = 2'd0,
      RSP_SHORT_CRC = 2'd1,
      RSP_LONG      = 2'd2,
      RSP_SHORT_RAW = 2'd3
   } rsp_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HUNT = 2'd1,
      ST_RECV = 2'd2
   } cap_state_e;
endpackage

// File: rtl/rspcap_seq.sv
module rspcap_seq
   import rspcap_pkg::*;
#(
   parameter int SHORT_BITS = 48,
   parameter int LONG_BITS  = 136,
   parameter int LONG_SKIP  = 8,
   parameter int CRC_SPAN   = 40,
   parameter int CRC_W      = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_issue,
   input  logic [1:0] cmd_type,
   input  logic       line_valid,
   input  logic       line_bit,
   input  logic       crc_match,
   output logic       pack_en,
   output logic       crc_calc_en,
   output logic       crc_rx_en,
   output logic       busy,
   output logic       done,
   output logic       crc_err
);
   localparam int IDX_W = $clog2(LONG_BITS + 1);
   localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_BITS - 1);
   localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_BITS - 1);
   localparam logic [IDX_W-1:0] SKIP_IDX   = IDX_W'(LONG_SKIP);
   localparam logic [IDX_W-1:0] SPAN_IDX   = IDX_W'(CRC_SPAN);
   localparam logic [IDX_W-1:0] RX_END_IDX = IDX_W'(CRC_SPAN + CRC_W);

   cap_state_e       state_q;
   rsp_kind_e        kind_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q, err_q;

   logic             take, last, checked;
   logic [IDX_W-1:0] cur_idx, last_idx;

   assign cur_idx  = (state_q == ST_HUNT) ? '0 : idx_q;
   assign last_idx = (kind_q == RSP_LONG) ? LONG_LAST : SHORT_LAST;
   assign last     = (cur_idx == last_idx);
   assign checked  = (kind_q == RSP_SHORT_CRC);

   always_comb begin
      take = 1'b0;
      if (line_valid && !cmd_issue) begin
         if (state_q == ST_HUNT) take = !line_bit;
         else if (state_q == ST_RECV) take = 1'b1;
      end
   end

   assign pack_en     = take && ((kind_q != RSP_LONG) || (cur_idx >= SKIP_IDX));
   assign crc_calc_en = take && checked && (cur_idx < SPAN_IDX);
   assign crc_rx_en   = take && checked && (cur_idx >= SPAN_IDX) && (cur_idx < RX_END_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= RSP_NONE;
         idx_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (cmd_issue) begin
            kind_q <= rsp_kind_e'(cmd_type);
            idx_q  <= '0;
            if (rsp_kind_e'(cmd_type) == RSP_NONE) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end else begin
               state_q <= ST_HUNT;
            end
         end else if (take) begin
            idx_q <= cur_idx + 1'b1;
            if (last) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
               err_q   <= checked && !crc_match;
            end else begin
               state_q <= ST_RECV;
            end
         end
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign crc_err = err_q;
endmodule

// File: rtl/rspcap_crc7.sv
module rspcap_crc7 #(
   parameter int CRC_W    = 7,
   parameter int CRC_POLY = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic calc_en,
   input  logic rx_en,
   input  logic bit_in,
   output logic match
);
   localparam logic [CRC_W-1:0] POLY = CRC_W'(CRC_POLY);

   logic [CRC_W-1:0] crc_q, rx_q, crc_nxt;
   logic             fb;

   assign fb = bit_in ^ crc_q[CRC_W-1];

   assign crc_nxt[0] = fb & POLY[0];
   for (genvar i = 1; i < CRC_W; i++) begin : g_tap
      assign crc_nxt[i] = crc_q[i-1] ^ (fb & POLY[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '0;
         rx_q  <= '0;
      end else if (clr) begin
         crc_q <= '0;
         rx_q  <= '0;
      end else begin
         if (calc_en) crc_q <= crc_nxt;
         if (rx_en)   rx_q  <= {rx_q[CRC_W-2:0], bit_in};
      end
   end

   assign match = (crc_q == rx_q);
endmodule

// File: rtl/rspcap_packer.sv
module rspcap_packer #(
   parameter int HW_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            en,
   input  logic            bit_in,
   output logic            push,
   output logic [HW_W-1:0] word
);
   localparam int CW = $clog2(HW_W);
   localparam logic [CW-1:0] CNT_LAST = CW'(HW_W - 1);

   logic [HW_W-2:0] sh_q;
   logic [CW-1:0]   cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (en) begin
         sh_q  <= {sh_q[HW_W-3:0], bit_in};
         cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   assign push = en && (cnt_q == CNT_LAST);
   assign word = {sh_q, bit_in};
endmodule

// File: rtl/rspcap_hwfifo.sv
module rspcap_hwfifo #(
   parameter int HW_W  = 16,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic [HW_W-1:0]              wdata,
   input  logic                         pop,
   output logic [HW_W-1:0]              rdata,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   logic [HW_W-1:0] mem [DEPTH];
   logic [AW-1:0]   wptr_q, rptr_q;
   logic [CW-1:0]   cnt_q;
   logic            do_push, do_pop;

   assign do_push = push && (cnt_q != CNT_FULL);
   assign do_pop  = pop && (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wptr_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
         if (do_pop)  rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rdata = (cnt_q == '0) ? '0 : mem[rptr_q];
   assign count = cnt_q;
endmodule

// File: rtl/rsp_capture.sv
module rsp_capture #(
   parameter int HW_W       = 16,
   parameter int FIFO_DEPTH = 8,
   parameter int SHORT_BITS = 48,
   parameter int LONG_BITS  = 136,
   parameter int CRC_SPAN   = 40,
   parameter int CRC_W      = 7,
   parameter int CRC_POLY   = 9
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cmd_issue,
   input  logic [1:0]                        cmd_rsp_type,
   input  logic                              line_valid,
   input  logic                              line_bit,
   input  logic                              pop,
   output logic [HW_W-1:0]                   pop_data,
   output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_count,
   output logic                              rsp_busy,
   output logic                              rsp_done,
   output logic                              rsp_crc_err
);
   localparam int LONG_SKIP = LONG_BITS - FIFO_DEPTH * HW_W;

   if (SHORT_BITS % HW_W != 0) begin : g_bad_short
      $error("short frame must be a whole number of halfwords");
   end
   if (LONG_SKIP < 0) begin : g_bad_depth
      $error("queue too shallow for a long frame");
   end
   if (SHORT_BITS / HW_W > FIFO_DEPTH) begin : g_bad_short_depth
      $error("queue too shallow for a short frame");
   end
   if (CRC_SPAN + CRC_W + 1 != SHORT_BITS) begin : g_bad_crc_span
      $error("CRC span and width must fill the short frame");
   end

   logic pack_en, crc_calc_en, crc_rx_en, crc_match;
   logic push;
   logic [HW_W-1:0] word;

   rspcap_seq #(
      .SHORT_BITS(SHORT_BITS),
      .LONG_BITS (LONG_BITS),
      .LONG_SKIP (LONG_SKIP),
      .CRC_SPAN  (CRC_SPAN),
      .CRC_W     (CRC_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_issue  (cmd_issue),
      .cmd_type   (cmd_rsp_type),
      .line_valid (line_valid),
      .line_bit   (line_bit),
      .crc_match  (crc_match),
      .pack_en    (pack_en),
      .crc_calc_en(crc_calc_en),
      .crc_rx_en  (crc_rx_en),
      .busy       (rsp_busy),
      .done       (rsp_done),
      .crc_err    (rsp_crc_err)
   );

   rspcap_crc7 #(
      .CRC_W   (CRC_W),
      .CRC_POLY(CRC_POLY)
   ) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cmd_issue),
      .calc_en(crc_calc_en),
      .rx_en  (crc_rx_en),
      .bit_in (line_bit),
      .match  (crc_match)
   );

   rspcap_packer #(.HW_W(HW_W)) u_pack (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cmd_issue),
      .en    (pack_en),
      .bit_in(line_bit),
      .push  (push),
      .word  (word)
   );

   rspcap_hwfifo #(.HW_W(HW_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .flush(cmd_issue),
      .push (push),
      .wdata(word),
      .pop  (pop),
      .rdata(pop_data),
      .count(fifo_count)
   );
endmodule

// File: rtl/rsp_capture_chk.sv
module rsp_capture_chk #(
   parameter int HW_W       = 16,
   parameter int FIFO_DEPTH = 8
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            cmd_issue,
   input logic [1:0]                      cmd_rsp_type,
   input logic                            pop,
   input logic [HW_W-1:0]                 pop_data,
   input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
   input logic                            rsp_busy,
   input logic                            rsp_done,
   input logic                            rsp_crc_err
);
   logic [1:0] type_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) type_seen <= 2'd0;
      else if (cmd_issue) type_seen <= cmd_rsp_type;
   end

   // R4: done is a single-cycle pulse unless a no-response command retriggers it
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !cmd_issue) |=> !rsp_done);

   // R4: capture is finished when done is reported
   a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !rsp_busy);

   // R4: a no-response command completes in the next cycle
   a_r4_none_done: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_issue && cmd_rsp_type == 2'd0) |=> rsp_done);

   // R5: CRC error only together with done
   a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_crc_err |-> rsp_done);

   // R5: CRC error only for the checked short type
   a_r5_err_type: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_crc_err |-> (type_seen == 2'd1));

   // R6: empty queue reads zero
   a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == '0) |-> (pop_data == '0));

   // R7: issue empties the queue
   a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_issue |=> (fifo_count == '0));

   // R2: occupancy never exceeds the depth
   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));
endmodule

bind rsp_capture rsp_capture_chk #(.HW_W(HW_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_issue   (cmd_issue),
   .cmd_rsp_type(cmd_rsp_type),
   .pop         (pop),
   .pop_data    (pop_data),
   .fifo_count  (fifo_count),
   .rsp_busy    (rsp_busy),
   .rsp_done    (rsp_done),
   .rsp_crc_err (rsp_crc_err)
);

// File: tb/tb_rsp_capture.sv
module tb_rsp_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_issue = 1'b0;
   logic [1:0]  cmd_rsp_type = 2'd0;
   logic        line_valid = 1'b0;
   logic        line_bit = 1'b1;
   logic        pop = 1'b0;
   logic [15:0] pop_data;
   logic [3:0]  fifo_count;
   logic        rsp_busy, rsp_done, rsp_crc_err;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] exp_q[$];

   always #4 clk = ~clk;

   rsp_capture dut (
      .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .cmd_rsp_type(cmd_rsp_type),
      .line_valid(line_valid), .line_bit(line_bit), .pop(pop), .pop_data(pop_data),
      .fifo_count(fifo_count), .rsp_busy(rsp_busy), .rsp_done(rsp_done),
      .rsp_crc_err(rsp_crc_err)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [6:0] crc7(input logic [39:0] d);
      logic [6:0] c = 7'd0;
      for (int i = 39; i >= 0; i--) begin
         logic f = d[i] ^ c[6];
         c = {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
      end
      return c;
   endfunction

   function automatic logic [47:0] short_frame(input logic [5:0] idx, input logic [31:0] arg,
                                               input logic [6:0] crc_flip);
      logic [39:0] head = {2'b00, idx, arg};
      return {head, crc7(head) ^ crc_flip, 1'b1};
   endfunction

   task automatic issue(input logic [1:0] t);
      @(negedge clk);
      cmd_issue = 1'b1;
      cmd_rsp_type = t;
      @(negedge clk);
      cmd_issue = 1'b0;
   endtask

   // drives bits MSB first; every fifth bit is preceded by an unqualified low cycle (R8)
   task automatic send_bits(input logic [135:0] fr, input int len, input int idle);
      for (int k = 0; k < idle; k++) begin
         @(negedge clk); line_valid = 1'b1; line_bit = 1'b1;
      end
      for (int i = len - 1; i >= 0; i--) begin
         if (i % 5 == 2) begin
            @(negedge clk); line_valid = 1'b0; line_bit = 1'b0;
         end
         @(negedge clk); line_valid = 1'b1; line_bit = fr[i];
      end
      @(negedge clk); line_valid = 1'b0; line_bit = 1'b1;
   endtask

   task automatic expect_words(input logic [135:0] fr, input int len, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(fr[len - 1 - (len - 16 * n) - 16 * i -: 16]);
   endtask

   // monitor: pops and compares against the scoreboard
   task automatic drain(input string tag);
      while (exp_q.size() > 0) begin
         logic [15:0] e = exp_q.pop_front();
         @(negedge clk);
         check(tag, {16'd0, pop_data}, {16'd0, e});
         pop = 1'b1;
      end
      @(negedge clk);
      pop = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [47:0]  s;
      logic [135:0] l;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 reset count", 32'(fifo_count), 0);
      check("R6 reset data", 32'(pop_data), 0);
      check("R4 reset done", 32'(rsp_done), 0);
      check("R1 reset busy", 32'(rsp_busy), 0);

      // R1: bits with no armed capture are ignored
      send_bits(136'h0, 20, 0);
      check("R1 idle bits count", 32'(fifo_count), 0);
      check("R1 idle bits busy", 32'(rsp_busy), 0);

      // R2/R5/R8: checked short frame, good CRC
      s = short_frame(6'h11, 32'hDEAD_BEEF, 7'h00);
      issue(2'd1);
      check("R1 busy after issue", 32'(rsp_busy), 1);
      send_bits({88'd0, s}, 48, 3);
      check("R4 done short", 32'(rsp_done), 1);
      check("R5 good crc", 32'(rsp_crc_err), 0);
      check("R4 busy low", 32'(rsp_busy), 0);
      check("R2 count short", 32'(fifo_count), 3);
      @(negedge clk);
      check("R4 done single", 32'(rsp_done), 0);
      expect_words({88'd0, s}, 48, 3);
      drain("R2 short halfword");

      // R6: pop on empty
      @(negedge clk); pop = 1'b1;
      check("R6 empty data", 32'(pop_data), 0);
      @(negedge clk); pop = 1'b0;
      check("R6 empty count", 32'(fifo_count), 0);

      // R5: checked short, bad CRC
      s = short_frame(6'h02, 32'h1234_5678, 7'h01);
      issue(2'd1);
      send_bits({88'd0, s}, 48, 1);
      check("R5 bad crc done", 32'(rsp_done), 1);
      check("R5 bad crc flagged", 32'(rsp_crc_err), 1);
      expect_words({88'd0, s}, 48, 3);
      drain("R2 bad crc halfword");

      // R5: unchecked short, bad CRC not reported
      s = short_frame(6'h3F, 32'h00FF_A5C3, 7'h55);
      issue(2'd3);
      send_bits({88'd0, s}, 48, 0);
      check("R5 raw done", 32'(rsp_done), 1);
      check("R5 raw no err", 32'(rsp_crc_err), 0);
      expect_words({88'd0, s}, 48, 3);
      drain("R2 raw halfword");

      // R3: long frame
      l = {2'b00, 6'h3F, 32'h0123_4567, 32'h89AB_CDEF, 32'h5A5A_F00F, 31'h1357_2468, 1'b1};
      issue(2'd2);
      send_bits(l, 136, 2);
      check("R4 done long", 32'(rsp_done), 1);
      check("R5 long no err", 32'(rsp_crc_err), 0);
      check("R3 count long", 32'(fifo_count), 8);
      expect_words(l, 136, 8);
      drain("R3 long halfword");

      // R4: no response
      issue(2'd0);
      check("R4 none done", 32'(rsp_done), 1);
      check("R4 none count", 32'(fifo_count), 0);
      @(negedge clk);
      check("R4 none single", 32'(rsp_done), 0);

      // R7: abandon partial capture
      s = short_frame(6'h05, 32'hCAFE_0001, 7'h00);
      issue(2'd1);
      send_bits({88'd0, s}, 20, 0);
      check("R7 partial count", 32'(fifo_count), 1);
      issue(2'd1);
      check("R7 flushed", 32'(fifo_count), 0);
      s = short_frame(6'h06, 32'h7777_8888, 7'h00);
      send_bits({88'd0, s}, 48, 0);
      check("R7 restart done", 32'(rsp_done), 1);
      check("R7 restart crc", 32'(rsp_crc_err), 0);
      expect_words({88'd0, s}, 48, 3);
      drain("R7 restart halfword");

      // R7: unread halfwords flushed after one pop
      issue(2'd3);
      send_bits({88'd0, s}, 48, 0);
      @(negedge clk); pop = 1'b1;
      @(negedge clk); pop = 1'b0;
      check("R6 pop moves count", 32'(fifo_count), 2);
      issue(2'd0);
      check("R7 unread flushed", 32'(fifo_count), 0);
      check("R7 flushed data", 32'(pop_data), 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule